// File: doc/BRIEF.md
# Two-Port RAM with Mailbox Doorbells

This block is a synchronous memory with two independent access ports, called A and B, that share one clock. Either port can read or write any word at any time. On top of the storage, the two highest word addresses serve as mailboxes. When one port writes its outgoing mailbox, an interrupt flag is raised toward the other port. When that receiving port reads the same word, its flag is cleared. A message and its notification therefore travel in a single memory access, and the word itself stays readable like any other location. Software decides what the mailbox words mean.

Each port has an enable, a write strobe, an output enable, an address and a write data bus. Each port also has a registered read data bus and a driven interrupt output. The ports have no back-pressure: every enabled access is taken on the clock edge where it is presented. Read data appears on the edge after the read and is held until the next read on that port.

The address `TOP` is the all-ones address for the chosen width. `TOP-1` is the address just below it. Port A writes `TOP` to notify port B. Port B writes `TOP-1` to notify port A.

Top module: `dpram_mailbox`

## Requirements
- R1: A word written on either port is returned by a later read of that address on either port. Read data appears on the port's read bus one clock edge after the read is presented.
- R2: A read happens only when the port's enable and output enable are both 1 and its write strobe is 0. In every other cycle the port's read bus keeps its previous value.
- R3: A write happens only when the port's enable and write strobe are both 1. A write strobe with enable 0 leaves memory unchanged.
- R4: A port A write to `TOP` sets `b_irq` to 1 on the next edge.
- R5: A port B read of `TOP` clears `b_irq` on the next edge.
- R6: A port B write to `TOP-1` sets `a_irq` to 1 on the next edge.
- R7: A port A read of `TOP-1` clears `a_irq` on the next edge.
- R8: When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: A write by a port to its own incoming mailbox leaves both interrupt flags unchanged. Port A's incoming mailbox is `TOP-1` and port B's is `TOP`. Both mailbox words are stored and can be read back as data.
- R10: After reset, both interrupt flags and both read buses are 0. The interrupt outputs are active high and always driven.
- R11: A read of an address that the other port writes in the same cycle returns the value held before that write.
- R12: When both ports write the same address in the same cycle, port A's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write strobe |
| a_oe | input | 1 | Port A output enable |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| a_irq | output | 1 | Mailbox interrupt toward port A |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write strobe |
| b_oe | input | 1 | Port B output enable |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| b_irq | output | 1 | Mailbox interrupt toward port B |

## Verification
Two functions can land on one edge. The sending port can ring a mailbox in the same cycle that the receiving port reads it to clear the flag. Separately, one port can write a word in the same cycle that the other port reads or writes that same word. The bench drives both ports in one step for each of these cases. A behavioural reference model, updated on every edge, predicts the flags and read buses. The flag is expected to stay set, the reader is expected to see the previous contents, and on a double write the port A value is expected to survive.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  function automatic port_op_e decode_op(input logic en, input logic we, input logic oe);
    if (en && we)       return OP_WRITE;
    else if (en && oe)  return OP_READ;
    else                return OP_IDLE;
  endfunction
endpackage

// File: rtl/dpmb_ram.sv
module dpmb_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Port B is applied first so that port A's value wins on a shared address.
  always_ff @(posedge clk) begin
    if (b_wr) store[b_addr] <= b_wdata;
    if (a_wr) store[a_addr] <= a_wdata;
  end

  // Read-first: the array is sampled before this edge's writes land.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= store[a_addr];
      if (b_rd) b_rdata <= store[b_addr];
    end
  end

  // R2
  a_rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !a_rd |=> $stable(a_rdata));
  // R2
  b_rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !b_rd |=> $stable(b_rdata));
endmodule

// File: rtl/dpmb_doorbell.sv
module dpmb_doorbell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic              a_oe,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic              b_en,
  input  logic              b_we,
  input  logic              b_oe,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq
);
  // Mailbox toward B is the top word; mailbox toward A sits just below it.
  localparam logic [ADDR_W-1:0] MB_TO_B = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MB_TO_A = MB_TO_B - 1'b1;

  port_op_e a_op, b_op;
  logic a_wr, a_rd, b_wr, b_rd;

  always_comb begin
    a_op = decode_op(a_en, a_we, a_oe);
    b_op = decode_op(b_en, b_we, b_oe);
    a_wr = (a_op == OP_WRITE);
    a_rd = (a_op == OP_READ);
    b_wr = (b_op == OP_WRITE);
    b_rd = (b_op == OP_READ);
  end

  dpmb_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst(rst),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  logic a_set, a_clr, b_set, b_clr;
  assign a_set = b_wr && (b_addr == MB_TO_A);
  assign a_clr = a_rd && (a_addr == MB_TO_A);
  assign b_set = a_wr && (a_addr == MB_TO_B);
  assign b_clr = b_rd && (b_addr == MB_TO_B);

  dpmb_doorbell u_bell_a (.clk(clk), .rst(rst), .set_i(a_set), .clr_i(a_clr), .flag_o(a_irq));
  dpmb_doorbell u_bell_b (.clk(clk), .rst(rst), .set_i(b_set), .clr_i(b_clr), .flag_o(b_irq));

  // R4
  ring_b_chk: assert property (@(posedge clk) disable iff (rst)
    (a_en && a_we && a_addr == MB_TO_B) |=> b_irq);
  // R6
  ring_a_chk: assert property (@(posedge clk) disable iff (rst)
    (b_en && b_we && b_addr == MB_TO_A) |=> a_irq);
  // R7
  ack_a_chk: assert property (@(posedge clk) disable iff (rst)
    (a_en && a_oe && !a_we && a_addr == MB_TO_A && !(b_en && b_we && b_addr == MB_TO_A)) |=> !a_irq);
  // R9
  own_mb_a_chk: assert property (@(posedge clk) disable iff (rst)
    (a_en && a_we && a_addr == MB_TO_A && !(b_en && b_we && b_addr == MB_TO_A)) |=> $stable(a_irq));
  // R9
  own_mb_b_chk: assert property (@(posedge clk) disable iff (rst)
    (b_en && b_we && b_addr == MB_TO_B && !(a_en && a_we && a_addr == MB_TO_B)) |=> $stable(b_irq));
endmodule

// File: tb/dpram_mailbox_bench.sv
module dpram_mailbox_bench;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam logic [AW-1:0] TOPA = {AW{1'b1}};
  localparam logic [AW-1:0] TOPM = TOPA - 1'b1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic a_en, a_we, a_oe, b_en, b_we, b_oe;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_irq, b_irq;

  dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) u_dpram_mailbox (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_oe(a_oe), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_en(b_en), .b_we(b_we), .b_oe(b_oe), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [DW-1:0] mm [int];
  logic [DW-1:0] ea, eb;
  logic ia, ib;

  task automatic chk(string tag, string nm, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "a_rdata", a_rdata, ea);
    chk(tag, "b_rdata", b_rdata, eb);
    chk(tag, "a_irq", {7'd0, a_irq}, {7'd0, ia});
    chk(tag, "b_irq", {7'd0, b_irq}, {7'd0, ib});
  endtask

  task automatic step(string tag,
                      logic aen, logic awe, logic aoe, logic [AW-1:0] aad, logic [DW-1:0] awd,
                      logic ben, logic bwe, logic boe, logic [AW-1:0] bad, logic [DW-1:0] bwd);
    bit ard, awr, brd, bwr, sa, ca, sb, cb;
    a_en = aen; a_we = awe; a_oe = aoe; a_addr = aad; a_wdata = awd;
    b_en = ben; b_we = bwe; b_oe = boe; b_addr = bad; b_wdata = bwd;
    @(posedge clk);
    awr = aen && awe;  ard = aen && aoe && !awe;
    bwr = ben && bwe;  brd = ben && boe && !bwe;
    if (ard) ea = mm[int'(aad)];
    if (brd) eb = mm[int'(bad)];
    if (bwr) mm[int'(bad)] = bwd;
    if (awr) mm[int'(aad)] = awd;
    sa = bwr && bad == TOPM;  ca = ard && aad == TOPM;
    sb = awr && aad == TOPA;  cb = brd && bad == TOPA;
    ia = sa ? 1'b1 : (ca ? 1'b0 : ia);
    ib = sb ? 1'b1 : (cb ? 1'b0 : ib);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic a_wr(string t, logic [AW-1:0] ad, logic [DW-1:0] d);
    step(t, 1, 1, 0, ad, d, 0, 0, 0, '0, '0);
  endtask
  task automatic b_wr(string t, logic [AW-1:0] ad, logic [DW-1:0] d);
    step(t, 0, 0, 0, '0, '0, 1, 1, 0, ad, d);
  endtask
  task automatic a_rd(string t, logic [AW-1:0] ad);
    step(t, 1, 0, 1, ad, '0, 0, 0, 0, '0, '0);
  endtask
  task automatic b_rd(string t, logic [AW-1:0] ad);
    step(t, 0, 0, 0, '0, '0, 1, 0, 1, ad, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1;
    a_en = 0; a_we = 0; a_oe = 0; a_addr = '0; a_wdata = '0;
    b_en = 0; b_we = 0; b_oe = 0; b_addr = '0; b_wdata = '0;
    ea = '0; eb = '0; ia = 0; ib = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    compare_all("R10");

    // R1: basic write and cross read
    a_wr("R1", 11'h010, 8'h5A);
    b_wr("R1", 11'h020, 8'hC3);
    step("R1", 1, 0, 1, 11'h020, '0, 1, 0, 1, 11'h010, '0);
    // R3: strobe without enable, and enable without strobe or output enable
    step("R3", 0, 1, 0, 11'h010, 8'hFF, 0, 1, 0, 11'h020, 8'hEE);
    step("R3", 1, 0, 0, 11'h010, 8'h77, 1, 0, 0, 11'h020, 8'h66);
    a_rd("R3", 11'h010);
    b_rd("R3", 11'h020);
    // R2: output enable low keeps read buses
    step("R2", 1, 0, 0, 11'h020, '0, 1, 0, 0, 11'h010, '0);
    step("R2", 0, 0, 1, 11'h020, '0, 0, 0, 1, 11'h010, '0);

    // R4 / R5: doorbell toward B
    a_wr("R4", TOPA, 8'h11);
    step("R4", 0, 0, 0, '0, '0, 0, 0, 0, '0, '0);
    b_rd("R5", TOPA);
    // R6 / R7: doorbell toward A
    b_wr("R6", TOPM, 8'h22);
    a_rd("R7", TOPM);
    // R9: own incoming mailbox writes, data still readable
    a_wr("R9", TOPM, 8'h33);
    b_wr("R9", TOPA, 8'h44);
    step("R9", 1, 0, 1, TOPA, '0, 1, 0, 1, TOPM, '0);

    // R8: ring and acknowledge on the same edge, both flags
    a_wr("R8", TOPA, 8'h55);
    step("R8", 1, 1, 0, TOPA, 8'h66, 1, 0, 1, TOPA, '0);
    b_rd("R8", TOPA);
    b_wr("R8", TOPM, 8'h77);
    step("R8", 1, 0, 1, TOPM, '0, 1, 1, 0, TOPM, 8'h88);
    a_rd("R8", TOPM);

    // R11: read of a word being written by the other port
    a_wr("R11", 11'h030, 8'h01);
    step("R11", 1, 1, 0, 11'h030, 8'h02, 1, 0, 1, 11'h030, '0);
    b_rd("R11", 11'h030);
    // R12: collision of two writes
    step("R12", 1, 1, 0, 11'h040, 8'hAA, 1, 1, 0, 11'h040, 8'hBB);
    a_rd("R12", 11'h040);
    b_rd("R12", 11'h040);

    // R1: mixed traffic over a small address pool that includes both mailboxes
    for (int i = 0; i < 8; i++) a_wr("R1", 11'(i), 8'(i * 17));
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] pa, pb;
      logic [2:0] ca, cb;
      int ra, rb;
      ra = $urandom_range(0, 9);
      rb = $urandom_range(0, 9);
      pa = (ra == 8) ? TOPM : (ra == 9) ? TOPA : AW'(ra);
      pb = (rb == 8) ? TOPM : (rb == 9) ? TOPA : AW'(rb);
      ca = 3'($urandom_range(0, 7));
      cb = 3'($urandom_range(0, 7));
      step("R1", ca[0], ca[1], ca[2], pa, 8'($urandom),
                 cb[0], cb[1], cb[2], pb, 8'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule